// File: doc/BRIEF.md
# Offset-Paced Synchronous Bus Writer

This block sends a stream of 9-bit words (eight data bits plus a parity bit, passed through unchanged) onto a parallel bus. Each word is qualified by an active-low request strobe. The receiver answers every strobe with an acknowledge pulse. A write begins with a one-cycle `start` pulse, which samples a transfer-period code and an offset. From the period code the block derives three strobe timing delays. From the offset it derives a credit preload and a divider. Together these bound how far strobes may run ahead of returned acknowledges.

Outstanding words are tracked by a four-slot credit pool. The pool starts at the preload level. It gains one token for every `divider` words launched and loses one token for every `divider` acknowledge rising edges. A new word is launched only while the pool is not full. The write completes when no input word is pending, the strobe sequencer is idle, the pool has fallen back to its preload, and the synchronized acknowledge is low. If completion does not arrive within `TIMEOUT_CYCLES` cycles of `start`, the write is aborted and a timeout flag is raised.

Top module: `paced_bus_writer`

## Requirements
- R1: After reset, and while no write is running, `bus_db` is all ones, `bus_req_n` is 1 and `in_ready` is 0. `done` and `timeout_flag` are 0 after reset and are both cleared by `start`.
- R2: Every word runs through three phases. SETUP drives the word for lead+1 cycles with `bus_req_n` high. STROBE holds `bus_req_n` low for width+1 cycles. HOLD keeps `bus_req_n` high for trail+1 cycles. Back-to-back words therefore show falling strobe edges exactly lead+width+trail+3 cycles apart.
- R3: When `cfg_period` ≤ 25, lead is 3 and width is 5. Otherwise lead is 6 and width is 12.
- R4: trail = floor(`cfg_period`*4/8) − lead − width − 3, clamped to the range 0..15.
- R5: While `bus_req_n` is low, `bus_db` holds the accepted word (bit 8 is the parity bit). Words appear in the order they were accepted.
- R6: The divider and preload are chosen by offset range. For offset ≤ 4 the divider is 1 and the preload is 5−offset. For offset ≤ 8 the divider is 2 and the preload is 5−offset/2 (integer division). For offset ≤ 16 the divider is 4 and the preload is 5−offset/4. Above 16 the divider is 4 and the preload is 0. Launches stall while the pool holds 4 tokens, so without acknowledges exactly (4−preload)×divider strobes are issued.
- R7: The preload never exceeds 3; for example, offset 1 yields preload 3.
- R8: A token is added after each `divider` launched words and removed after each `divider` acknowledge rising edges. An acknowledge that finds the pool empty removes nothing. An add and a remove in the same cycle leave the level unchanged.
- R9: `ack_in` passes through two synchronizer flops. It is counted once per rising edge, however long it stays high.
- R10: `done` rises only when `in_valid` is 0, the sequencer is idle, the pool level is at or below the preload, and the synchronized acknowledge is low. It then holds, with the bus released, until the next `start`. A write with no words completes within a few cycles.
- R11: If `done` has not risen `TIMEOUT_CYCLES` cycles after `start`, `timeout_flag` rises, the write stops and the bus is released in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse: sample configuration and begin a write |
| cfg_period | input | PW | Negotiated transfer-period code |
| cfg_offset | input | OW | Negotiated offset |
| in_valid | input | 1 | Input word available |
| in_word | input | DW | Data byte plus parity bit in bit 8 |
| in_ready | output | 1 | Word accepted this cycle |
| ack_in | input | 1 | Asynchronous acknowledge from the receiver, active high |
| bus_db | output | DW | Data and parity lines, all ones when released |
| bus_req_n | output | 1 | Active-low request strobe |
| done | output | 1 | All words sent and acknowledged |
| timeout_flag | output | 1 | Write aborted by timeout |

## Verification
The delicate coincidence is a token add from a word launch landing in the same cycle as a token removal from an acknowledge edge. The pool must then keep its level rather than gain or lose a token. This coincidence is provoked by sweeping the acknowledge latency across the timing scenarios, so that synchronized edges land on launch cycles of back-to-back words. A second coincidence sits at the stall boundary: an acknowledge arrives while the pool is full and unblocks exactly one more launch. Both are judged at the ports. The bench compares exact strobe counts after each added acknowledge with (4−preload)×divider, and requires `done` to come only when the pool has returned to its preload.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
  localparam int CREDIT_SLOTS = 4;
  localparam int PRELOAD_CAP  = 3;
  localparam int DLY_W        = 4;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;

  typedef struct packed {
    logic [DLY_W-1:0] lead;
    logic [DLY_W-1:0] width;
    logic [DLY_W-1:0] trail;
    logic [1:0]       div_m1;
    logic [1:0]       preload;
  } pace_t;

  // Timing delays and credit settings from the negotiated period/offset.
  function automatic pace_t derive_pace(input int period, input int offset);
    pace_t p;
    int tot, d0, d1, d2, pre, dv;
    tot = (period * 4) / 8;
    if (period <= 25) begin d0 = 3; d1 = 5; end
    else              begin d0 = 6; d1 = 12; end
    d2 = tot - d0 - d1 - 3;
    if (d2 < 0) d2 = 0;
    if (d2 > (1 << DLY_W) - 1) d2 = (1 << DLY_W) - 1;
    if (offset <= 4)       begin dv = 1; pre = 5 - offset;     end
    else if (offset <= 8)  begin dv = 2; pre = 5 - offset / 2; end
    else if (offset <= 16) begin dv = 4; pre = 5 - offset / 4; end
    else                   begin dv = 4; pre = 0;              end
    if (pre > PRELOAD_CAP) pre = PRELOAD_CAP;
    p.lead    = DLY_W'(d0);
    p.width   = DLY_W'(d1);
    p.trail   = DLY_W'(d2);
    p.div_m1  = 2'(dv - 1);
    p.preload = 2'(pre);
    return p;
  endfunction
endpackage

// File: rtl/pbw_cfg_decode.sv
module pbw_cfg_decode
  import pbw_pkg::*;
#(
  parameter int PW = 8,
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] period,
  input  logic [OW-1:0] offset,
  output pace_t         pace_d,
  output pace_t         pace_q
);
  always_comb pace_d = derive_pace(int'(period), int'(offset));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pace_q <= '0;
    else if (load) pace_q <= pace_d;
  end
endmodule

// File: rtl/pbw_ack_sync.sv
module pbw_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_in,
  output logic ack_lvl,
  output logic ack_rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], ack_in};
  end

  assign ack_lvl  = sh_q[STAGES-1];
  assign ack_rise = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R9
  ack_rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rise |=> !ack_rise);
endmodule

// File: rtl/pbw_credit_pool.sv
module pbw_credit_pool #(
  parameter  int SLOTS = 4,
  localparam int LW    = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [1:0]    preload,
  input  logic [1:0]    div_m1,
  input  logic          launch,
  input  logic          ack_rise,
  output logic [LW-1:0] level,
  output logic          full
);
  logic [LW-1:0] lvl_q, lvl_d;
  logic [1:0]    psub_q, psub_d, dsub_q, dsub_d;
  logic          push, drain;

  always_comb begin
    push  = launch && (psub_q == div_m1);
    drain = ack_rise && (dsub_q == div_m1) && (lvl_q != '0);
    if (clear) begin
      lvl_d  = LW'(preload);
      psub_d = '0;
      dsub_d = '0;
    end else begin
      lvl_d  = lvl_q + LW'(push) - LW'(drain);
      psub_d = launch   ? ((psub_q == div_m1) ? 2'd0 : psub_q + 2'd1) : psub_q;
      dsub_d = ack_rise ? ((dsub_q == div_m1) ? 2'd0 : dsub_q + 2'd1) : dsub_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      psub_q <= '0;
      dsub_q <= '0;
    end else begin
      lvl_q  <= lvl_d;
      psub_q <= psub_d;
      dsub_q <= dsub_d;
    end
  end

  assign level = lvl_q;
  assign full  = (lvl_q == LW'(SLOTS));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !full);
  // R8
  push_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && push && drain) |=> $stable(lvl_q));
endmodule

// File: rtl/pbw_strobe_seq.sv
module pbw_strobe_seq
  import pbw_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          can_go,
  input  logic [DW-1:0] word,
  input  pace_t         pace,
  output logic          take,
  output logic [DW-1:0] bus_db,
  output logic          req_n,
  output logic          idle
);
  phase_e           st_q, st_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic [DW-1:0]    dat_q;
  logic             expired;

  always_comb begin
    expired = (cnt_q == '0);
    take    = can_go && ((st_q == PH_IDLE) || ((st_q == PH_HOLD) && expired));
    st_d    = st_q;
    cnt_d   = cnt_q;
    if (take) begin
      st_d  = PH_SETUP;
      cnt_d = pace.lead;
    end else begin
      case (st_q)
        PH_SETUP:  if (expired) begin st_d = PH_STROBE; cnt_d = pace.width; end
                   else cnt_d = cnt_q - 1'b1;
        PH_STROBE: if (expired) begin st_d = PH_HOLD; cnt_d = pace.trail; end
                   else cnt_d = cnt_q - 1'b1;
        PH_HOLD:   if (expired) st_d = PH_IDLE;
                   else cnt_d = cnt_q - 1'b1;
        default:   ;
      endcase
    end
    if (!enable) begin
      st_d  = PH_IDLE;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dat_q <= '0;
    else if (take) dat_q <= word;
  end

  assign idle   = (st_q == PH_IDLE);
  assign req_n  = (st_q != PH_STROBE);
  assign bus_db = idle ? '1 : dat_q;

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && $past(!req_n)) |-> $stable(bus_db));
endmodule

// File: rtl/paced_bus_writer.sv
module paced_bus_writer
  import pbw_pkg::*;
#(
  parameter  int DW             = 9,
  parameter  int PW             = 8,
  parameter  int OW             = 8,
  parameter  int TIMEOUT_CYCLES = 100000,
  localparam int TW             = $clog2(TIMEOUT_CYCLES + 1),
  localparam int LW             = $clog2(CREDIT_SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] cfg_period,
  input  logic [OW-1:0] cfg_offset,
  input  logic          in_valid,
  input  logic [DW-1:0] in_word,
  output logic          in_ready,
  input  logic          ack_in,
  output logic [DW-1:0] bus_db,
  output logic          bus_req_n,
  output logic          done,
  output logic          timeout_flag
);
  pace_t         pace_d, pace_q;
  logic          ack_lvl, ack_rise, take, seq_idle, full, can_go, finish;
  logic [LW-1:0] level;
  logic          run_q, run_d, done_q, done_d, to_q, to_d;
  logic [TW-1:0] tmr_q, tmr_d;

  pbw_cfg_decode #(.PW(PW), .OW(OW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(start), .period(cfg_period), .offset(cfg_offset),
    .pace_d(pace_d), .pace_q(pace_q));

  pbw_ack_sync #(.STAGES(2)) u_ack (
    .clk(clk), .rst_n(rst_n), .ack_in(ack_in), .ack_lvl(ack_lvl), .ack_rise(ack_rise));

  pbw_credit_pool #(.SLOTS(CREDIT_SLOTS)) u_credit (
    .clk(clk), .rst_n(rst_n), .clear(start), .preload(pace_d.preload),
    .div_m1(pace_q.div_m1), .launch(take), .ack_rise(ack_rise), .level(level), .full(full));

  pbw_strobe_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(run_d), .can_go(can_go), .word(in_word),
    .pace(pace_q), .take(take), .bus_db(bus_db), .req_n(bus_req_n), .idle(seq_idle));

  always_comb begin
    finish = run_q && !start && !in_valid && seq_idle &&
             (level <= LW'(pace_q.preload)) && !ack_lvl;
    run_d  = run_q;
    done_d = done_q;
    to_d   = to_q;
    tmr_d  = tmr_q;
    if (start) begin
      run_d  = 1'b1;
      done_d = 1'b0;
      to_d   = 1'b0;
      tmr_d  = '0;
    end else if (run_q) begin
      if (finish) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end else if (tmr_q == TW'(TIMEOUT_CYCLES - 1)) begin
        run_d = 1'b0;
        to_d  = 1'b1;
      end else begin
        tmr_d = tmr_q + 1'b1;
      end
    end
    can_go = run_q && run_d && in_valid && !full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      to_q   <= 1'b0;
      tmr_q  <= '0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      to_q   <= to_d;
      tmr_q  <= tmr_d;
    end
  end

  assign in_ready     = take;
  assign done         = done_q;
  assign timeout_flag = to_q;

  // R10
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bus_req_n && (bus_db == '1)));
  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  // R11
  timeout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |-> (bus_req_n && !done));
endmodule

// File: tb/tb_paced_bus_writer.sv
module tb_paced_bus_writer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [7:0] cfg_period, cfg_offset;
  logic       in_valid, in_ready, ack_in, bus_req_n, done, timeout_flag;
  logic [8:0] in_word, bus_db;

  always #5 clk = ~clk;

  paced_bus_writer #(.TIMEOUT_CYCLES(3000)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_period(cfg_period), .cfg_offset(cfg_offset),
    .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready), .ack_in(ack_in),
    .bus_db(bus_db), .bus_req_n(bus_req_n), .done(done), .timeout_flag(timeout_flag));

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  // word source
  logic [8:0] src_mem [0:255];
  int src_idx = 0, src_n = 0;
  assign in_valid = (src_idx < src_n);
  assign in_word  = src_mem[src_idx % 256];
  always @(posedge clk) if (in_valid && in_ready) src_idx <= src_idx + 1;

  // bus monitor
  int cyc = 0, req_falls = 0, last_fall = 0, last_spacing = 0, low_run = 0, last_low_w = 0;
  int db_chg = 0, setup_w = 0;
  logic prev_req = 1'b1;
  logic [8:0] prev_db = '1;
  logic [8:0] cap [0:255];
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (bus_db !== prev_db) db_chg = cyc;
    if (prev_req && !bus_req_n) begin
      cap[req_falls % 256] = bus_db;
      req_falls = req_falls + 1;
      last_spacing = cyc - last_fall;
      last_fall = cyc;
      setup_w = cyc - db_chg;
    end
    if (!bus_req_n) low_run = low_run + 1;
    else begin
      if (!prev_req) last_low_w = low_run;
      low_run = 0;
    end
    prev_req = bus_req_n;
    prev_db = bus_db;
  end

  // automatic acknowledge responder
  bit resp_en = 0;
  int resp_lat = 2;
  initial forever begin
    @(negedge bus_req_n);
    if (resp_en) begin
      repeat (resp_lat) @(negedge clk);
      ack_in = 1'b1;
      repeat (3) @(negedge clk);
      ack_in = 1'b0;
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic exp_pace(input int per, input int off, output int d0, output int d1,
                          output int d2, output int dv, output int pre);
    int tot;
    tot = per / 2;
    d0 = (per <= 25) ? 3 : 6;
    d1 = (per <= 25) ? 5 : 12;
    d2 = tot - d0 - d1 - 3;
    if (d2 < 0) d2 = 0;
    if (d2 > 15) d2 = 15;
    if (off <= 4) begin dv = 1; pre = 5 - off; end
    else if (off <= 8) begin dv = 2; pre = 5 - off / 2; end
    else if (off <= 16) begin dv = 4; pre = 5 - off / 4; end
    else begin dv = 4; pre = 0; end
    if (pre > 3) pre = 3;
  endtask

  function automatic logic [8:0] gen_word(input int i, input int seed);
    return 9'((i * 73 + 19 + seed) & 9'h1FF);
  endfunction

  int base_req, acks_given;

  task automatic load_words(input int n, input int seed);
    for (int i = 0; i < n; i++) src_mem[(src_idx + i) % 256] = gen_word(i, seed);
    src_n = src_idx + n;
  endtask

  task automatic begin_write(input int per, input int off);
    cfg_period = 8'(per);
    cfg_offset = 8'(off);
    base_req = req_falls;
    acks_given = 0;
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic ack_pulse();
    ack_in = 1'b1;
    tick(4);
    ack_in = 1'b0;
    tick(4);
    acks_given++;
  endtask

  task automatic ack_until_done();
    int guard = 0;
    while (!done && guard < 2500) begin
      if (acks_given < req_falls - base_req) ack_pulse();
      else tick();
      guard++;
    end
  endtask

  task automatic check_data(input int n, input int seed, input string tag);
    for (int i = 0; i < n; i++)
      chk(cap[(base_req + i) % 256] == gen_word(i, seed), tag,
          int'(cap[(base_req + i) % 256]), int'(gen_word(i, seed)));
  endtask

  task automatic t_reset();
    chk(bus_req_n == 1'b1, "R1 req_n after reset", int'(bus_req_n), 1);
    chk(bus_db == 9'h1FF, "R1 bus_db after reset", int'(bus_db), 511);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    chk(timeout_flag == 1'b0, "R1 timeout after reset", int'(timeout_flag), 0);
    chk(in_ready == 1'b0, "R1 in_ready after reset", int'(in_ready), 0);
  endtask

  task automatic t_timing(input int per, input int lat, input int seed);
    int d0, d1, d2, dv, pre, guard;
    exp_pace(per, 4, d0, d1, d2, dv, pre);
    resp_lat = lat;
    resp_en = 1;
    load_words(6, seed);
    begin_write(per, 4);
    chk(bus_db == 9'h1FF && bus_req_n, "R1 released at start", int'(bus_db), 511);
    guard = 0;
    while (!done && guard < 2000) begin tick(); guard++; end
    resp_en = 0;
    chk(done == 1'b1, "R10 done after acked write", int'(done), 1);
    chk(req_falls - base_req == 6, "R5 strobe count", req_falls - base_req, 6);
    check_data(6, seed, "R5 word order");
    chk(last_low_w == d1 + 1, "R2 R3 strobe low width", last_low_w, d1 + 1);
    chk(setup_w == d0 + 1, "R2 R3 setup before strobe", setup_w, d0 + 1);
    chk(last_spacing == d0 + d1 + d2 + 3, "R2 R4 strobe spacing", last_spacing, d0 + d1 + d2 + 3);
  endtask

  task automatic t_offset(input int off, input int e0, input int e1, input int e2, input int seed);
    int d0, d1, d2, dv, pre;
    exp_pace(25, off, d0, d1, d2, dv, pre);
    chk((4 - pre) * dv == e0, "R6 R7 model limit", (4 - pre) * dv, e0);
    load_words(20, seed);
    begin_write(25, off);
    tick(300);
    chk(req_falls - base_req == e0, "R6 R7 strobes without ack", req_falls - base_req, e0);
    ack_pulse();
    tick(60);
    chk(req_falls - base_req == e1, "R8 strobes after one ack", req_falls - base_req, e1);
    ack_pulse();
    tick(60);
    chk(req_falls - base_req == e2, "R8 strobes after two acks", req_falls - base_req, e2);
    ack_until_done();
    chk(done == 1'b1, "R10 done after lazy acks", int'(done), 1);
    chk(req_falls - base_req == 20, "R5 all words sent", req_falls - base_req, 20);
    check_data(20, seed, "R5 word order paced");
  endtask

  task automatic t_ack_hold();
    load_words(2, 7);
    begin_write(25, 1);
    tick(100);
    chk(req_falls - base_req == 1, "R7 offset one single strobe", req_falls - base_req, 1);
    ack_in = 1'b1;
    tick(60);
    chk(req_falls - base_req == 2, "R9 held ack counted once", req_falls - base_req, 2);
    chk(done == 1'b0, "R10 not done while ack high", int'(done), 0);
    ack_in = 1'b0;
    tick(20);
    chk(done == 1'b0, "R10 not done above preload", int'(done), 0);
    ack_in = 1'b1;
    tick(4);
    ack_in = 1'b0;
    tick(8);
    chk(done == 1'b1, "R10 done at preload", int'(done), 1);
    chk(bus_db == 9'h1FF && bus_req_n, "R10 bus released when done", int'(bus_db), 511);
  endtask

  task automatic t_timeout();
    load_words(5, 3);
    begin_write(25, 4);
    tick(2900);
    chk(timeout_flag == 1'b0, "R11 no early timeout", int'(timeout_flag), 0);
    tick(150);
    chk(timeout_flag == 1'b1, "R11 timeout raised", int'(timeout_flag), 1);
    chk(done == 1'b0, "R11 not done on timeout", int'(done), 0);
    chk(bus_req_n && bus_db == 9'h1FF, "R11 bus released on timeout", int'(bus_db), 511);
    chk(req_falls - base_req == 3, "R11 stalled strobes", req_falls - base_req, 3);
    src_n = src_idx;
    tick(5);
    chk(in_ready == 1'b0, "R1 no fetch while stopped", int'(in_ready), 0);
    ack_in = 1'b0;
    begin_write(25, 4);
    chk(timeout_flag == 1'b0, "R1 start clears timeout", int'(timeout_flag), 0);
    tick(6);
    chk(done == 1'b1, "R10 empty write completes", int'(done), 1);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    ack_in = 1'b0;
    cfg_period = 8'd25;
    cfg_offset = 8'd4;
    tick(4);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_timing(25, 2, 1);
    t_timing(25, 5, 2);
    t_timing(50, 5, 3);
    t_timing(100, 2, 4);
    t_timing(26, 3, 5);
    t_offset(4, 3, 4, 5, 11);
    t_offset(1, 1, 2, 3, 12);
    t_offset(6, 4, 4, 6, 13);
    t_offset(20, 16, 16, 16, 14);
    t_ack_hold();
    t_timeout();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule